// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 31 pins. Software configures pin direction through an output-enable word and drives output levels through two write-one registers: one raises bits and one lowers them, so no read-modify-write is needed. The pin inputs pass through a two-stage synchroniser and can be read back as a word.

Each pin has an interrupt detector. Its controls are an enable bit, a mask bit, a mode bit (level or edge) and a polarity bit. The results collect in a pending word, and every pending bit that has both its enable and its mask set feeds one combined interrupt line. A build parameter flips the meaning of the output-enable bits for integrations where a 1 means "input".

The register port takes one request per cycle and never stalls, so it has no ready signal. A read request returns its data one cycle later, marked by `rsp_valid`. Writes take effect at the clock edge that accepts them.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pin_out` is zero, `irq` is low, and with the normal enable sense `pin_oe` is zero.
- R2: The direction register (byte offset 0x00) stores the low NPINS bits written to it, and bits at or above NPINS read as zero. With `OE_INVERT`=0, `pin_oe` equals the stored bits.
- R3: With `OE_INVERT`=1, `pin_oe` is the bitwise inverse of the stored direction bits, so after reset every pin drives.
- R4: A write to the raise register (0x0C) sets each output bit written as 1. A write to the lower register (0x10) clears each output bit written as 1. Bits written as 0 keep their value. Reading either offset returns the current output word.
- R5: The input register (0x04) returns `pin_in` after two clock edges of synchronisation. A read accepted at the first edge after a change still returns the old value.
- R6: When a pin's mode bit (0x18) is 0, it detects edges. A polarity bit (0x1C) of 1 selects rising edges and 0 selects falling edges. A qualifying edge on an enabled pin (0x14) sets its pending bit (0x20) at the third edge after the pin changes. The bit stays set until a 1 is written to it at 0x20.
- R7: An edge on a pin whose enable bit is 0 does not set its pending bit.
- R8: When a pin's mode bit is 1, it is level sensitive. Its pending bit follows, one edge late, the condition "enabled and synchronised input equals polarity". Writing 1 to the pending bit has no lasting effect while that condition holds.
- R9: `irq` is high exactly when some pin has its pending bit, its enable bit and its mask bit (0x24) all set.
- R10: A read request produces `rsp_valid` high in the next cycle, with the addressed word on `rsp_data`. Offsets not listed in R2 to R9 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (cycle after a read request) |
| rsp_data | output | 32 | Read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Per-pin drive enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `bus_addr` is word-aligned and that `pin_in` changes no more than once per clock. They also assume that software clears pending bits only through the pending offset. The bench changes pins only at falling clock edges and holds each level for at least three cycles before it checks a result, so every edge passes through the synchroniser as a single clean transition. Mode and polarity changes are made while the affected pin input is steady. This matches the disable-reconfigure-enable order that the detector relies on.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFF_DIR  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_IN   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_RAISE = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_LOWER = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_MODE = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_POL  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_PEND = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_MASK = 6'h24;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      stage1 <= async_in;
      cur    <= stage1;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic prev,
  input  logic en,
  input  logic level_mode,
  input  logic pol,
  input  logic clr,
  output logic pend
);
  logic active, edge_hit, pend_nx;

  always_comb begin
    active   = (cur == pol);
    edge_hit = (cur != prev) && active;
    if (level_mode) pend_nx = en && active;
    else            pend_nx = (en && edge_hit) || (pend && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_nx;
  end

  // R7: a disabled edge pin cannot gain a pending bit
  a_r7_no_edge_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !en && !pend) |=> !pend);
  // R8: a disabled level pin drops its pending bit
  a_r8_level_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && !en) |=> !pend);
  // R6: an edge pending bit holds until cleared
  a_r6_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && pend && !clr) |=> pend);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter bit OE_INVERT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int PAD = 32 - NPINS;

  logic [NPINS-1:0] dir_q, out_q, ien_q, mode_q, pol_q, mask_q;
  logic [NPINS-1:0] in_cur, in_prev, pend, clr_vec, wd;
  logic             wr, rd;
  logic [31:0]      rd_word;
  wire              unused_hi = &{1'b0, bus_wdata[31:NPINS]};

  assign wr = bus_valid && bus_write;
  assign rd = bus_valid && !bus_write;
  assign wd = bus_wdata[NPINS-1:0];
  assign clr_vec = (wr && bus_addr == OFF_PEND) ? wd : '0;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .cur(in_cur), .prev(in_prev)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin_irq u_det (
      .clk(clk), .rst_n(rst_n), .cur(in_cur[i]), .prev(in_prev[i]),
      .en(ien_q[i]), .level_mode(mode_q[i]), .pol(pol_q[i]),
      .clr(clr_vec[i]), .pend(pend[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      mask_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFF_DIR:   dir_q  <= wd;
        OFF_RAISE: out_q  <= out_q | wd;
        OFF_LOWER: out_q  <= out_q & ~wd;
        OFF_IEN:   ien_q  <= wd;
        OFF_MODE:  mode_q <= wd;
        OFF_POL:   pol_q  <= wd;
        OFF_MASK:  mask_q <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    logic [NPINS-1:0] sel;
    case (bus_addr)
      OFF_DIR:   sel = dir_q;
      OFF_IN:    sel = in_cur;
      OFF_RAISE: sel = out_q;
      OFF_LOWER: sel = out_q;
      OFF_IEN:   sel = ien_q;
      OFF_MODE:  sel = mode_q;
      OFF_POL:   sel = pol_q;
      OFF_PEND:  sel = pend;
      OFF_MASK:  sel = mask_q;
      default:   sel = '0;
    endcase
    rd_word = {{PAD{1'b0}}, sel};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= rd_word;
    end
  end

  assign pin_out = out_q;
  if (OE_INVERT) begin : g_oe_inv
    assign pin_oe = ~dir_q;
  end else begin : g_oe_norm
    assign pin_oe = dir_q;
  end
  assign irq = |(pend & ien_q & mask_q);

  // R4: bits written to the raise register are high afterwards
  a_r4_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFF_RAISE) |=> ((pin_out & $past(wd)) == $past(wd)));
  // R4: bits written to the lower register are low afterwards
  a_r4_lower_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFF_LOWER) |=> ((pin_out & $past(wd)) == '0));
  // R9: the combined request needs an enabled and unmasked pin
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(ien_q & mask_q)));
  // R10: exactly one response per read request
  a_r10_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  a_r10_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          rsp_valid, rsp_valid_i;
  logic [31:0]   rsp_data, rsp_data_i;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_out_i, pin_oe_i;
  logic          irq, irq_i;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP), .OE_INVERT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq));

  gpio_irq_ctrl #(.NPINS(NP), .OE_INVERT(1'b1)) dut_inv (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid_i),
    .rsp_data(rsp_data_i), .pin_in(pin_in), .pin_out(pin_out_i), .pin_oe(pin_oe_i),
    .irq(irq_i));

  // {write, addr, data, expected read}
  localparam int NV = 16;
  localparam logic [72:0] VECS [NV] = '{
    {1'b1, 8'h00, 32'hFFFF_FF0F, 32'h0},  // R2 direction write
    {1'b0, 8'h00, 32'h0, 32'h0000_000F},  // R2 upper bits drop
    {1'b1, 8'h0C, 32'h0000_00A5, 32'h0},  // R4 raise
    {1'b0, 8'h0C, 32'h0, 32'h0000_00A5},
    {1'b1, 8'h10, 32'h0000_0021, 32'h0},  // R4 lower
    {1'b0, 8'h0C, 32'h0, 32'h0000_0084},
    {1'b1, 8'h0C, 32'h0, 32'h0},          // R4 zero bits unchanged
    {1'b0, 8'h10, 32'h0, 32'h0000_0084},
    {1'b1, 8'h18, 32'h0000_003C, 32'h0},
    {1'b0, 8'h18, 32'h0, 32'h0000_003C},
    {1'b1, 8'h1C, 32'h0000_FFFF, 32'h0},
    {1'b0, 8'h1C, 32'h0, 32'h0000_00FF},
    {1'b1, 8'h24, 32'h0000_0081, 32'h0},
    {1'b0, 8'h24, 32'h0, 32'h0000_0081},
    {1'b0, 8'h08, 32'h0, 32'h0},          // R10 unmapped offset
    {1'b0, 8'h28, 32'h0, 32'h0}           // R10 unmapped offset
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R10 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    d = rsp_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // reset state
    chk("R1 pin_oe", {24'b0, pin_oe}, 32'h0);
    chk("R1 pin_out", {24'b0, pin_out}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R3 inverted pin_oe after reset", {24'b0, pin_oe_i}, 32'h0000_00FF);
    bus_rd(6'h00, r); chk("R1 direction reads zero", r, 32'h0);
    bus_rd(6'h20, r); chk("R1 pending reads zero", r, 32'h0);

    // register table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][72]) bus_wr(VECS[i][69:64], VECS[i][63:32]);
      else begin
        bus_rd(VECS[i][69:64], r);
        chk("R2/R4/R10 table read", r, VECS[i][31:0]);
      end
    end
    chk("R2 pin_oe follows register", {24'b0, pin_oe}, 32'h0000_000F);
    chk("R3 inverted pin_oe", {24'b0, pin_oe_i}, 32'h0000_00F0);
    chk("R4 pin_out", {24'b0, pin_out}, 32'h0000_0084);

    // input synchronisation
    @(negedge clk); pin_in = 8'h5A;
    bus_rd(6'h04, r); chk("R5 input not yet visible", r, 32'h0);
    bus_rd(6'h04, r); chk("R5 input visible", r, 32'h0000_005A);
    @(negedge clk); pin_in = 8'h00;
    tick(3);

    // edge detection on pin 0
    bus_wr(6'h18, 32'h02);
    bus_wr(6'h1C, 32'h01);
    bus_wr(6'h24, 32'h03);
    bus_wr(6'h14, 32'h01);
    chk("R9 no irq before edge", {31'b0, irq}, 32'h0);
    @(negedge clk); pin_in[0] = 1'b1;
    tick(2);
    chk("R6 pending not before third edge", {31'b0, irq}, 32'h0);
    tick(1);
    chk("R6 rising edge sets irq", {31'b0, irq}, 32'h1);
    bus_rd(6'h20, r); chk("R6 pending bit", r, 32'h1);
    bus_wr(6'h20, 32'h01);
    chk("R6 cleared by write one", {31'b0, irq}, 32'h0);
    bus_rd(6'h20, r); chk("R6 stays clear while high", r, 32'h0);

    bus_wr(6'h1C, 32'h00);
    @(negedge clk); pin_in[0] = 1'b0;
    tick(3);
    chk("R6 falling edge sets irq", {31'b0, irq}, 32'h1);
    bus_wr(6'h20, 32'h01);

    // mask gating
    bus_wr(6'h24, 32'h02);
    @(negedge clk); pin_in[0] = 1'b1;
    tick(3);
    bus_rd(6'h20, r); chk("R6 rising ignored in falling mode", r, 32'h0);
    @(negedge clk); pin_in[0] = 1'b0;
    tick(3);
    chk("R9 masked pin gives no irq", {31'b0, irq}, 32'h0);
    bus_rd(6'h20, r); chk("R9 pending still recorded", r, 32'h1);
    bus_wr(6'h24, 32'h03);
    chk("R9 unmask raises irq", {31'b0, irq}, 32'h1);
    bus_wr(6'h20, 32'h01);

    // disabled pin
    bus_wr(6'h14, 32'h00);
    @(negedge clk); pin_in[0] = 1'b1;
    tick(3);
    @(negedge clk); pin_in[0] = 1'b0;
    tick(3);
    bus_rd(6'h20, r); chk("R7 disabled pin ignores edges", r, 32'h0);
    chk("R7 no irq", {31'b0, irq}, 32'h0);

    // level detection on pin 1 (active low, input low)
    bus_wr(6'h14, 32'h02);
    tick(1);
    chk("R8 active-low level raises irq", {31'b0, irq}, 32'h1);
    bus_wr(6'h20, 32'h02);
    bus_rd(6'h20, r); chk("R8 clear has no effect while active", r, 32'h2);
    @(negedge clk); pin_in[1] = 1'b1;
    tick(3);
    chk("R8 inactive level drops irq", {31'b0, irq}, 32'h0);
    bus_rd(6'h20, r); chk("R8 pending follows level", r, 32'h0);
    bus_wr(6'h1C, 32'h02);
    tick(1);
    chk("R8 active-high level raises irq", {31'b0, irq}, 32'h1);
    bus_wr(6'h14, 32'h00);
    tick(1);
    chk("R8 disabling drops level pending", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule